// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous burst SRAM. It has a small word-organised array of 32-bit words, and each word is split into four byte lanes. On the rising clock edge the block captures the address, the write data, three chip enables, two address strobes, a burst-advance input and the write controls. From these it decides one of three actions: start a burst, continue the current burst, or deselect.

A burst covers four consecutive beats within an aligned group of four words. Beat order is either linear or interleaved. After the fourth beat the sequence wraps back to the starting word. Reads can be returned in flow-through mode or in pipelined mode. In flow-through mode the data is valid in the cycle that follows the capturing edge. In pipelined mode it passes through an output register and arrives one cycle later.

Output enable and sleep act on the output at once, without waiting for the clock. The model replaces the tri-state data bus with a separate valid flag. Sleep blocks new commands and keeps the stored contents.

Top module: `sbsram_core`

## Requirements
- R1: On a clock edge, a host strobe (`strb_host`) with `ce_a` high starts a read burst at `addr` if `ce_b` and `ce_c` are both high, and deselects otherwise. When `ce_a` is low, the host strobe is ignored and `strb_ctl` is evaluated instead.
- R2: With `flow_thru`=1, read data and `rvalid`=1 appear in the cycle after the edge that captured the read address.
- R3: With `flow_thru`=0, read data and `rvalid`=1 appear one cycle later than in R2. Tying `flow_thru` low gives this pipelined mode.
- R4: With `linear`=0 (the tied-low default), the low two address bits of beat k are the start address's low two bits XOR k. The fifth beat returns to the start word.
- R5: With `linear`=1, the low two address bits of beat k are (start + k) mod 4, and the upper bits stay fixed.
- R6: A byte write (`byte_wr`=1, `glob_wr`=0) updates only the lanes whose `byte_en` bits are set, in any pattern. Lane i is bits 8i+7..8i. With `byte_wr`=0 and `glob_wr`=0, `byte_en` writes nothing.
- R7: `glob_wr`=1 writes all four lanes, whatever `byte_wr` and `byte_en` are.
- R8: A controller strobe (`strb_ctl`) starts a burst only when all three chip enables are high. Otherwise it deselects and writes nothing. The burst it starts is a write if R6 or R7 selects any lane, and a read otherwise.
- R9: On cycles with no accepted strobe, the chip enables are ignored and an active burst continues.
- R10: Without a strobe, an active burst continues. `adv`=1 steps to the next beat and `adv`=0 holds the current word. The cycle is a write if the write controls select a lane, and a read otherwise.
- R11: Deselect takes effect in a single cycle. `rvalid` is low in the first output cycle that follows the deselecting edge.
- R12: `out_en`=0 or `sleep`=1 forces `rvalid` low at once, without a clock edge. While `sleep` is high, strobes and writes are ignored and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control and output state |
| addr | input | ADDR_W | Word address, captured when a burst starts |
| wdata | input | DATA_W | Write data |
| ce_a | input | 1 | Chip enable that also gates the host strobe |
| ce_b | input | 1 | Chip enable, sampled only with a strobe |
| ce_c | input | 1 | Chip enable, sampled only with a strobe |
| strb_host | input | 1 | Host address strobe (starts a read burst) |
| strb_ctl | input | 1 | Controller address strobe (starts a read or write burst) |
| adv | input | 1 | Advance to the next burst beat |
| byte_en | input | LANES | Per-lane write enables |
| byte_wr | input | 1 | Qualifies `byte_en` for a byte write |
| glob_wr | input | 1 | Write all lanes |
| linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| flow_thru | input | 1 | 1 = flow-through reads, 0 = pipelined reads |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request; contents retained |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | Read data valid (stands in for driven outputs) |

## Verification
The bench uses the default build: a 64-word array, a 6-bit address and four 8-bit lanes. With this size it can fill every word and start a five-beat burst from every address. It does this in each of the four combinations of burst order and read mode, so every start offset, every wrap and both latencies are compared against a reference array. The four lanes give only sixteen byte-enable patterns, so all of them are written and read back. The masking, hold, deselect, output-enable and sleep cases are then driven as targeted sequences.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_BURST,
        ST_WR_FIRST,
        ST_WR_BURST
    } seq_state_e;

    // Low two address bits of a beat given the start offset and beat count.
    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] cnt,
                                               input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              strb_host,
    input  logic              strb_ctl,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c,
    input  logic              adv,
    input  logic              wr_req,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_fire,
    output logic              rd_active,
    output logic              busy
);
    localparam int UP_W = ADDR_W - 2;

    typedef struct packed {
        seq_state_e       st;
        logic [UP_W-1:0]  upper;
        logic [1:0]       base;
        logic [1:0]       cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  start, start_wr;

    always_comb begin
        nxt_d    = cur_q;
        start    = 1'b0;
        start_wr = 1'b0;
        if (sleep) begin
            nxt_d.st = ST_IDLE;
        end else if (strb_host && ce_a) begin
            if (ce_b && ce_c) start = 1'b1;
            else              nxt_d.st = ST_IDLE;
        end else if (strb_ctl) begin
            if (ce_a && ce_b && ce_c) begin
                start    = 1'b1;
                start_wr = wr_req;
            end else begin
                nxt_d.st = ST_IDLE;
            end
        end else if (cur_q.st != ST_IDLE) begin
            if (adv) nxt_d.cnt = cur_q.cnt + 2'd1;
            nxt_d.st = wr_req ? ST_WR_BURST : ST_RD_BURST;
        end
        if (start) begin
            nxt_d.upper = addr[ADDR_W-1:2];
            nxt_d.base  = addr[1:0];
            nxt_d.cnt   = 2'd0;
            nxt_d.st    = start_wr ? ST_WR_FIRST : ST_RD_FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, upper: '0, base: 2'd0, cnt: 2'd0};
        else        cur_q <= nxt_d;
    end

    assign cur_addr  = {cur_q.upper, beat_offset(cur_q.base, cur_q.cnt, linear)};
    assign wr_addr   = {nxt_d.upper, beat_offset(nxt_d.base, nxt_d.cnt, linear)};
    assign wr_fire   = (nxt_d.st == ST_WR_FIRST) || (nxt_d.st == ST_WR_BURST);
    assign rd_active = (cur_q.st == ST_RD_FIRST) || (cur_q.st == ST_RD_BURST);
    assign busy      = (cur_q.st != ST_IDLE);

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_fire,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [0:DEPTH-1];

        always_ff @(posedge clk) begin
            if (wr_fire && lane_we[g]) mem_q[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

endmodule

// File: rtl/sbsram_rdpath.sv
module sbsram_rdpath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } pipe_t;

    pipe_t pipe_q, pipe_d;

    always_comb begin
        pipe_d.vld  = rd_active;
        pipe_d.data = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rdata  = flow_thru ? arr_data : pipe_q.data;
    assign rvalid = out_en && !sleep && (flow_thru ? rd_active : pipe_q.vld);

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c,
    input  logic              strb_host,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic [LANES-1:0]  byte_en,
    input  logic              byte_wr,
    input  logic              glob_wr,
    input  logic              linear,
    input  logic              flow_thru,
    input  logic              out_en,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [LANES-1:0]  lane_we;
    logic              wr_req;
    logic [ADDR_W-1:0] cur_addr, wr_addr;
    logic              wr_fire, rd_active, busy;
    logic [DATA_W-1:0] arr_data;

    always_comb begin
        if (glob_wr)      lane_we = '1;
        else if (byte_wr) lane_we = byte_en;
        else              lane_we = '0;
    end
    assign wr_req = |lane_we;

    sbsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep),
        .strb_host(strb_host), .strb_ctl(strb_ctl),
        .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
        .adv(adv), .wr_req(wr_req), .linear(linear), .addr(addr),
        .cur_addr(cur_addr), .wr_addr(wr_addr), .wr_fire(wr_fire),
        .rd_active(rd_active), .busy(busy)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .wr_fire(wr_fire), .wr_addr(wr_addr), .lane_we(lane_we),
        .wdata(wdata), .rd_addr(cur_addr), .rd_data(arr_data)
    );

    sbsram_rdpath #(.DATA_W(DATA_W)) u_rdpath (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .rd_active(rd_active),
        .arr_data(arr_data), .out_en(out_en), .sleep(sleep),
        .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk (
    input logic clk,
    input logic rst_n,
    input logic strb_host,
    input logic strb_ctl,
    input logic ce_a,
    input logic ce_b,
    input logic ce_c,
    input logic out_en,
    input logic sleep,
    input logic flow_thru,
    input logic rvalid,
    input logic rd_active,
    input logic busy
);
    assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en || sleep) |-> !rvalid);

    assert_sleep_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !busy);

    assert_host_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_host && !ce_a && !strb_ctl && !busy) |=> !busy);

    assert_ctl_dsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctl && !(ce_a && ce_b && ce_c) && !(strb_host && ce_a)) |=> !busy);

    assert_pipe_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && rvalid) |-> $past(rd_active));

    assert_flow_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && strb_host && ce_a && ce_b && ce_c && !sleep)
        |=> (rvalid || !out_en || sleep || !flow_thru));

endmodule

bind sbsram_core sbsram_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strb_host(strb_host), .strb_ctl(strb_ctl),
    .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .out_en(out_en), .sleep(sleep),
    .flow_thru(flow_thru), .rvalid(rvalid), .rd_active(rd_active), .busy(busy)
);

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ce_a = 1'b1, ce_b = 1'b1, ce_c = 1'b1;
    logic        strb_host = 1'b0, strb_ctl = 1'b0, adv = 1'b0;
    logic [3:0]  byte_en = '0;
    logic        byte_wr = 1'b0, glob_wr = 1'b0;
    logic        linear = 1'b0, flow_thru = 1'b0;
    logic        out_en = 1'b1, sleep = 1'b0;
    logic [31:0] rdata;
    logic        rvalid;

    logic [31:0] ref_mem [0:63];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sbsram_core u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
        .strb_host(strb_host), .strb_ctl(strb_ctl), .adv(adv),
        .byte_en(byte_en), .byte_wr(byte_wr), .glob_wr(glob_wr),
        .linear(linear), .flow_thru(flow_thru), .out_en(out_en), .sleep(sleep),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [1:0] offs(input logic [1:0] b, input logic [1:0] k);
        return linear ? (b + k) : (b ^ k);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        strb_host = 1'b0; strb_ctl = 1'b0; adv = 1'b0;
        byte_wr = 1'b0; glob_wr = 1'b0; byte_en = '0;
        ce_a = 1'b1; ce_b = 1'b1; ce_c = 1'b1;
    endtask

    task automatic desel_in();
        idle_in();
        strb_ctl = 1'b1; ce_a = 1'b0;
    endtask

    task automatic expect_read(input logic [31:0] exp, input string tag);
        chk({31'd0, rvalid}, 32'd1, tag);
        chk(rdata, exp, tag);
    endtask

    task automatic write_raw(input logic [5:0] a, input logic [31:0] d,
                             input logic [3:0] be, input logic bw, input logic gw);
        logic [3:0] m;
        idle_in();
        strb_ctl = 1'b1; addr = a; wdata = d; byte_en = be; byte_wr = bw; glob_wr = gw;
        step();
        desel_in();
        step();
        m = gw ? 4'hF : (bw ? be : 4'h0);
        for (int l = 0; l < 4; l++)
            if (m[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic read_single(input logic [5:0] a, input string tag);
        idle_in();
        strb_host = 1'b1; addr = a;
        step();
        desel_in();
        if (flow_thru) begin
            expect_read(ref_mem[a], tag);
            step();
        end else begin
            step();
            expect_read(ref_mem[a], tag);
            step();
        end
        chk({31'd0, rvalid}, 32'd0, {tag, "/R11"});
    endtask

    task automatic burst_run(input logic [5:0] a);
        logic [31:0] exp_q [0:4];
        string tag;
        tag = $sformatf("%s/%s", linear ? "R5" : "R4", flow_thru ? "R2" : "R3");
        for (int c = 0; c < 5; c++) exp_q[c] = ref_mem[{a[5:2], offs(a[1:0], 2'(c))}];
        for (int c = 0; c < 6; c++) begin
            idle_in();
            if (c == 0) begin strb_host = 1'b1; addr = a; end
            else if (c < 5) adv = 1'b1;
            else desel_in();
            step();
            if (flow_thru && c < 5) expect_read(exp_q[c], tag);
            else if (!flow_thru && c >= 1) expect_read(exp_q[c-1], tag);
        end
        desel_in();
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({31'd0, rvalid}, 32'd0, "R11 reset");

        // Fill every word with a global write (R7).
        for (int i = 0; i < 64; i++) write_raw(6'(i), 32'h9E3779B9 * (i + 1), 4'h0, 1'b0, 1'b1);

        // Defaults: flow_thru=0, linear=0 -> pipelined, interleaved (R3, R4).
        for (int mode = 0; mode < 4; mode++) begin
            linear = mode[0]; flow_thru = mode[1];
            for (int a = 0; a < 64; a++) burst_run(6'(a));
        end

        // Byte-lane writes, every pattern (R6).
        flow_thru = 1'b1; linear = 1'b0;
        for (int be = 0; be < 16; be++) begin
            write_raw(6'(16 + be), 32'hF00D0000 | (be * 32'h1111), 4'(be), 1'b1, 1'b0);
            read_single(6'(16 + be), "R6 pattern");
        end
        write_raw(6'd3, 32'hDEADBEEF, 4'hF, 1'b0, 1'b0);
        read_single(6'd3, "R6 no byte_wr");
        write_raw(6'd4, 32'h12345678, 4'h0, 1'b0, 1'b1);
        read_single(6'd4, "R7 glob no lanes");
        write_raw(6'd5, 32'h87654321, 4'h5, 1'b1, 1'b1);
        read_single(6'd5, "R7 glob over bytes");

        // Pipelined single read checks too (R3).
        flow_thru = 1'b0;
        read_single(6'd5, "R3 single");
        flow_thru = 1'b1;

        // Chip-enable masking (R1, R8).
        idle_in(); strb_host = 1'b1; ce_a = 1'b0; addr = 6'd7;
        step(); chk({31'd0, rvalid}, 32'd0, "R1 host masked");
        idle_in(); strb_host = 1'b1; ce_b = 1'b0; addr = 6'd7;
        step(); chk({31'd0, rvalid}, 32'd0, "R1 host ce_b low");
        idle_in(); strb_ctl = 1'b1; ce_c = 1'b0; addr = 6'd7;
        step(); chk({31'd0, rvalid}, 32'd0, "R8 ctl ce_c low");
        idle_in(); strb_ctl = 1'b1; addr = 6'd7;
        step(); expect_read(ref_mem[7], "R8 ctl read");
        desel_in(); step();
        idle_in(); strb_ctl = 1'b1; ce_b = 1'b0; glob_wr = 1'b1; addr = 6'd8; wdata = 32'hBAD0BAD0;
        step(); desel_in(); step();
        read_single(6'd8, "R8 masked write");

        // Enables ignored mid-burst (R9).
        idle_in(); strb_host = 1'b1; addr = 6'h21;
        step(); expect_read(ref_mem[6'h21], "R9 start");
        idle_in(); ce_a = 1'b0; ce_b = 1'b0; ce_c = 1'b0; adv = 1'b1;
        step(); expect_read(ref_mem[{4'h8, offs(2'd1, 2'd1)}], "R9 continue");
        desel_in(); step();

        // Hold with adv low (R10).
        idle_in(); strb_host = 1'b1; addr = 6'h12;
        step(); expect_read(ref_mem[6'h12], "R10 start");
        idle_in();
        step(); expect_read(ref_mem[6'h12], "R10 hold");
        adv = 1'b1;
        step(); expect_read(ref_mem[{4'h4, offs(2'd2, 2'd1)}], "R10 advance");
        desel_in(); step();

        // Write burst in both orders (R10, R4, R5).
        for (int lm = 0; lm < 2; lm++) begin
            linear = lm[0];
            for (int c = 0; c < 4; c++) begin
                idle_in(); glob_wr = 1'b1; wdata = 32'hC0DE0000 + (lm * 16) + c;
                if (c == 0) begin strb_ctl = 1'b1; addr = 6'h2D; end else adv = 1'b1;
                step();
                ref_mem[{4'hB, offs(2'd1, 2'(c))}] = 32'hC0DE0000 + (lm * 16) + c;
            end
            desel_in(); step();
            for (int c = 0; c < 4; c++) read_single({4'hB, 2'(c)}, "R10 write burst");
        end

        // Output enable (R12).
        idle_in(); strb_host = 1'b1; addr = 6'd9;
        step();
        out_en = 1'b0; #1;
        chk({31'd0, rvalid}, 32'd0, "R12 out_en");
        out_en = 1'b1; #1;
        expect_read(ref_mem[9], "R12 out_en restore");
        desel_in(); step();

        // Sleep (R12).
        idle_in(); strb_host = 1'b1; addr = 6'd10;
        step();
        sleep = 1'b1; #1;
        chk({31'd0, rvalid}, 32'd0, "R12 sleep gate");
        idle_in(); strb_ctl = 1'b1; glob_wr = 1'b1; addr = 6'd10; wdata = 32'h0BADF00D;
        step();
        sleep = 1'b0;
        desel_in(); step();
        read_single(6'd10, "R12 sleep retain");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule